// File: doc/BRIEF.md
# Inter-CPU NMI Rendezvous Latch

This block lets two processors each raise a non-maskable interrupt in the other, with a handshake that does not care about ordering. There is one latch for each direction. Inside a direction, the processor that will receive the interrupt arms its latch by writing to its rendezvous port. The other processor triggers that same latch by reading the rendezvous port on its own side. The interrupt goes out only when both actions have happened. Whichever action comes second fires the interrupt and returns the latch to idle. Each processor uses a single port address for two jobs: a write to it arms the latch aimed at that processor, and a read from it triggers the latch aimed at the other processor.

Each latch is a three-state machine named for its flags. RV_IDLE (code 00) has no flag set. RV_ARMED (code 01) has the enable flag in bit 0. RV_PENDING (code 10) has the pending flag in bit 1. The transitions are:
- IDLE→ARMED on a lone arm.
- IDLE→PENDING on a lone trigger.
- ARMED→IDLE (fire) on a trigger.
- PENDING→IDLE (fire) on an arm.
- IDLE→IDLE (fire) when arm and trigger come in the same clock.
- ARMED stays ARMED on a repeated arm.
- PENDING stays PENDING on a repeated trigger.

A fire is registered and then stretched to `NMI_WIDTH` clocks by a reloadable down-counter.

Top module: `nmi_rv_pair`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, both NMI outputs are low and both latches are in RV_IDLE, so a lone trigger or a lone arm after reset fires nothing.
- R2: An arm followed later by a trigger of the same latch fires that latch's NMI on the trigger.
- R3: A trigger followed later by an arm of the same latch fires that latch's NMI on the arm.
- R4: An arm and a trigger of the same latch in the same clock fire that NMI.
- R5: After a fire the latch is back in RV_IDLE, so the next lone arm or lone trigger does not fire.
- R6: Repeated arms without a trigger, or repeated triggers without an arm, never fire.
- R7: The NMI output goes high in the cycle after the clock edge that samples the completing strobe, and stays high for exactly `NMI_WIDTH` cycles.
- R8: A read data bus is all ones (8'hFF for width 8) while its read strobe is high, and zero otherwise.
- R9: The directions are cross-wired and independent. `a_port_wr` arms the latch that drives `nmi_a`, and `b_port_rd` triggers it. `b_port_wr` arms the latch that drives `nmi_b`, and `a_port_rd` triggers it. Activity on one latch never raises the other NMI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_port_wr | input | 1 | CPU A write strobe on its rendezvous port (arms the latch for A) |
| a_port_rd | input | 1 | CPU A read strobe on its rendezvous port (triggers the latch for B) |
| b_port_wr | input | 1 | CPU B write strobe on its rendezvous port (arms the latch for B) |
| b_port_rd | input | 1 | CPU B read strobe on its rendezvous port (triggers the latch for A) |
| a_rd_data | output | DATA_W | Read data returned to CPU A |
| b_rd_data | output | DATA_W | Read data returned to CPU B |
| nmi_a | output | 1 | Stretched NMI pulse to CPU A |
| nmi_b | output | 1 | Stretched NMI pulse to CPU B |

## Verification
The bound checker watches several properties on every cycle:
- A latch never holds both flags at once.
- An arm against RV_PENDING, or a trigger against RV_ARMED, raises the NMI in the next cycle and leaves the latch idle.
- An NMI never rises without a strobe in the cycle before.
- The read data is all ones whenever its read strobe is high.

Some behaviour only the bench's sweep can show. It runs every three-step sequence of idle, arm, trigger and simultaneous events on both directions from reset. That covers the exact pulse width and the absence of a pulse after repeated one-sided accesses. It also covers the quiet cycle after the stretch and the silence of the opposite NMI.

// File: rtl/nmi_rv_pkg.sv
package nmi_rv_pkg;
    // Flag encoding: bit 0 = enable (armed), bit 1 = pending (triggered)
    typedef enum logic [1:0] {
        RV_IDLE    = 2'b00,
        RV_ARMED   = 2'b01,
        RV_PENDING = 2'b10
    } rv_state_e;

    localparam int RV_DIRS = 2;
endpackage

// File: rtl/nmi_rv_latch.sv
module nmi_rv_latch
    import nmi_rv_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      arm_i,
    input  logic      trig_i,
    output logic      fire_o,
    output rv_state_e state_o
);
    rv_state_e state_q, state_d;
    logic      fire_d;

    always_comb begin
        state_d = state_q;
        fire_d  = 1'b0;
        unique case (state_q)
            RV_IDLE: begin
                if (arm_i && trig_i) begin
                    fire_d = 1'b1;
                end else if (arm_i) begin
                    state_d = RV_ARMED;
                end else if (trig_i) begin
                    state_d = RV_PENDING;
                end
            end
            RV_ARMED: begin
                if (trig_i) begin
                    fire_d  = 1'b1;
                    state_d = RV_IDLE;
                end
            end
            RV_PENDING: begin
                if (arm_i) begin
                    fire_d  = 1'b1;
                    state_d = RV_IDLE;
                end
            end
            default: state_d = RV_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RV_IDLE;
        else        state_q <= state_d;
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fire_o <= 1'b0;
        else        fire_o <= fire_d;
    end

    assign state_o = state_q;
endmodule

// File: rtl/nmi_rv_stretch.sv
module nmi_rv_stretch #(
    parameter int NMI_WIDTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    output logic nmi_o
);
    localparam int CW = (NMI_WIDTH > 1) ? $clog2(NMI_WIDTH) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(NMI_WIDTH - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt_q <= '0;
        else if (fire_i)       cnt_q <= RELOAD;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign nmi_o = fire_i || (cnt_q != '0);
endmodule

// File: rtl/nmi_rv_pair.sv
module nmi_rv_pair
    import nmi_rv_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int NMI_WIDTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_port_wr,
    input  logic              a_port_rd,
    input  logic              b_port_wr,
    input  logic              b_port_rd,
    output logic [DATA_W-1:0] a_rd_data,
    output logic [DATA_W-1:0] b_rd_data,
    output logic              nmi_a,
    output logic              nmi_b
);
    // Index 0 targets CPU A, index 1 targets CPU B
    logic      arm_v  [RV_DIRS];
    logic      trig_v [RV_DIRS];
    logic      fire_v [RV_DIRS];
    logic      nmi_v  [RV_DIRS];
    rv_state_e st_v   [RV_DIRS];

    assign arm_v[0]  = a_port_wr;
    assign trig_v[0] = b_port_rd;
    assign arm_v[1]  = b_port_wr;
    assign trig_v[1] = a_port_rd;

    for (genvar g = 0; g < RV_DIRS; g++) begin : g_dir
        nmi_rv_latch u_latch (
            .clk     (clk),
            .rst_n   (rst_n),
            .arm_i   (arm_v[g]),
            .trig_i  (trig_v[g]),
            .fire_o  (fire_v[g]),
            .state_o (st_v[g])
        );
        nmi_rv_stretch #(.NMI_WIDTH(NMI_WIDTH)) u_stretch (
            .clk    (clk),
            .rst_n  (rst_n),
            .fire_i (fire_v[g]),
            .nmi_o  (nmi_v[g])
        );
    end

    assign nmi_a = nmi_v[0];
    assign nmi_b = nmi_v[1];

    assign a_rd_data = a_port_rd ? {DATA_W{1'b1}} : '0;
    assign b_rd_data = b_port_rd ? {DATA_W{1'b1}} : '0;
endmodule

// File: rtl/nmi_rv_checker.sv
module nmi_rv_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              a_port_wr,
    input logic              a_port_rd,
    input logic              b_port_wr,
    input logic              b_port_rd,
    input logic [DATA_W-1:0] a_rd_data,
    input logic [DATA_W-1:0] b_rd_data,
    input logic              nmi_a,
    input logic              nmi_b,
    input logic [1:0]        st_a,
    input logic [1:0]        st_b
);
    p_flags_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(st_a) <= 1) && ($countones(st_b) <= 1));

    p_trig_fires_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (b_port_rd && st_a == 2'b01) |=> (nmi_a && st_a == 2'b00));

    p_arm_fires_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (a_port_wr && st_a == 2'b10) |=> (nmi_a && st_a == 2'b00));

    p_trig_fires_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (a_port_rd && st_b == 2'b01) |=> (nmi_b && st_b == 2'b00));

    p_arm_fires_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (b_port_wr && st_b == 2'b10) |=> (nmi_b && st_b == 2'b00));

    p_both_fires_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (a_port_wr && b_port_rd) |=> nmi_a);

    p_rise_needs_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_a) |-> $past(a_port_wr || b_port_rd));

    p_rise_needs_strobe_b_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_b) |-> $past(b_port_wr || a_port_rd));

    p_rd_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (a_port_rd |-> (&a_rd_data)) and (b_port_rd |-> (&b_rd_data)));
endmodule

bind nmi_rv_pair nmi_rv_checker #(.DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .a_port_wr (a_port_wr),
    .a_port_rd (a_port_rd),
    .b_port_wr (b_port_wr),
    .b_port_rd (b_port_rd),
    .a_rd_data (a_rd_data),
    .b_rd_data (b_rd_data),
    .nmi_a     (nmi_a),
    .nmi_b     (nmi_b),
    .st_a      (st_v[0]),
    .st_b      (st_v[1])
);

// File: tb/nmi_rv_pair_tb.sv
module nmi_rv_pair_tb_top;
    localparam int W  = 4;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          a_port_wr = 1'b0, a_port_rd = 1'b0;
    logic          b_port_wr = 1'b0, b_port_rd = 1'b0;
    logic [DW-1:0] a_rd_data, b_rd_data;
    logic          nmi_a, nmi_b;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    nmi_rv_pair #(.DATA_W(DW), .NMI_WIDTH(W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .a_port_wr(a_port_wr), .a_port_rd(a_port_rd),
        .b_port_wr(b_port_wr), .b_port_rd(b_port_rd),
        .a_rd_data(a_rd_data), .b_rd_data(b_rd_data),
        .nmi_a(nmi_a), .nmi_b(nmi_b)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        a_port_wr = 0; a_port_rd = 0; b_port_wr = 0; b_port_rd = 0;
        #1;
        chk("R1 nmi_a in reset", nmi_a, 0);
        chk("R1 nmi_b in reset", nmi_b, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 nmi_a after reset", nmi_a, 0);
        chk("R1 nmi_b after reset", nmi_b, 0);
    endtask

    // model flags: 0 idle, 1 armed, 2 pending
    task automatic run_step(input int tgt, input bit arm, input bit trig, inout int fl);
        bit    fire;
        string tag;
        if (tgt == 0) begin a_port_wr = arm; b_port_rd = trig; end
        else          begin b_port_wr = arm; a_port_rd = trig; end
        #1;
        chk("R8 a_rd_data", a_rd_data, (tgt == 1 && trig) ? 32'hFF : 32'h0);
        chk("R8 b_rd_data", b_rd_data, (tgt == 0 && trig) ? 32'hFF : 32'h0);
        fire = 0;
        tag  = "R6 no fire";
        if (arm && trig) begin fire = 1; tag = "R4 same-clock fire"; fl = 0; end
        else if (trig && fl == 1) begin fire = 1; tag = "R2 arm then trigger"; fl = 0; end
        else if (arm && fl == 2) begin fire = 1; tag = "R3 trigger then arm"; fl = 0; end
        else if (arm) fl = 1;
        else if (trig) fl = 2;
        @(posedge clk);
        @(negedge clk);
        a_port_wr = 0; a_port_rd = 0; b_port_wr = 0; b_port_rd = 0;
        for (int c = 1; c <= W + 1; c++) begin
            #1;
            if (c == 1) chk(tag, (tgt == 0) ? nmi_a : nmi_b, fire);
            else        chk("R7 pulse width", (tgt == 0) ? nmi_a : nmi_b, (fire && c <= W) ? 1 : 0);
            chk("R9 other nmi quiet", (tgt == 0) ? nmi_b : nmi_a, 0);
            @(negedge clk);
        end
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1/R5/R6: sweep every three-step event sequence from reset on each direction
        for (int tgt = 0; tgt < 2; tgt++) begin
            for (int s = 0; s < 64; s++) begin
                int fl;
                fl = 0;
                do_reset();
                for (int k = 0; k < 3; k++) begin
                    int ev;
                    ev = (s >> (2 * k)) & 3;
                    run_step(tgt, ev[0], ev[1], fl);
                end
            end
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule